// File: doc/BRIEF.md
# Dual-Bus Decimating Channel Loader

The loader takes 12-bit pixel words from two input buses and distributes them into a bank of twelve channel registers. The twelve registers are double-buffered into a bank of output holding registers. Bus A always feeds the even-numbered channels and bus B always feeds the odd-numbered ones. A single strobe does two jobs. The rising edge after the strobe is sampled copies the completed bank to the outputs, and the same edge starts filling the bank again.

The fill can run in either direction across the channels, which allows mirrored images. There are two bus modes. In single-bus mode, one word arrives per clock edge, so a word is taken on the rising edge and another on the falling edge. In dual-bus mode, both buses are sampled together on the rising edge. In both modes one clock cycle fills one even/odd channel pair, so the whole bank fills in six cycles. Falling-edge words are caught by a small negative-edge capture stage and written into the rising-edge bank one edge later. The whole bank and its outputs therefore stay in a single clock domain.

Top module: `pixel_chan_loader`

## Requirements
- R1: A synchronous reset, held across at least one rising edge, clears every channel word and output code to zero and holds `xfer_o` low. A transfer made before any data is loaded presents all-zero codes.
- R2: When `start_i` is high at rising edge E, the next rising edge E+1 copies all twelve channel words to `codes_o`. `xfer_o` is then high for exactly the one cycle following E+1. Between transfers `codes_o` does not change. Channel c appears at `codes_o[12*c+11 : 12*c]`, with bit 11 as the MSB.
- R3: In dual-bus mode (`dual_i`=1) with `dir_i`=0, rising edge E+1+k (k = 0 to 5) writes `bus_a_i` to channel 2k and `bus_b_i` to channel 2k+1.
- R4: In dual-bus mode with `dir_i`=1, rising edge E+1+k writes `bus_a_i` to channel 10-2k and `bus_b_i` to channel 11-2k. Loading therefore starts at channel 11 and ends at channel 0.
- R5: In single-bus mode (`dual_i`=0) with `dir_i`=0, rising edge E+1+k writes `bus_a_i` to channel 2k. The falling edge that follows writes `bus_b_i` to channel 2k+1.
- R6: In single-bus mode with `dir_i`=1, rising edge E+1+k writes `bus_b_i` to channel 11-2k. The falling edge that follows writes `bus_a_i` to channel 10-2k.
- R7: `dual_i` and `dir_i` are sampled at edge E+1. Changes to them while that sequence is loading have no effect on it.
- R8: After six channel pairs have been written, bus data is ignored until the next transfer.
- R9: A strobe that arrives before all twelve channels are loaded still commits the current contents. Channels not yet rewritten keep their earlier words. Loading then restarts from the first channel.
- R10: If the strobe is sampled on the edge that writes the last pair in single-bus mode, the transfer that follows includes the final falling-edge word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data in single-bus mode |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer/start strobe, sampled on the rising edge |
| dir_i | input | 1 | Fill direction: 0 = upward from channel 0, 1 = downward from channel 11 |
| dual_i | input | 1 | Bus mode: 0 = single-bus (both edges), 1 = dual-bus (rising only) |
| bus_a_i | input | 12 | Data word for the even channels |
| bus_b_i | input | 12 | Data word for the odd channels |
| codes_o | output | 144 | Twelve held 12-bit codes, channel c in bits 12c+11 down to 12c |
| xfer_o | output | 1 | One-cycle pulse following each transfer |

## Verification
The bench changes the falling-edge bus value only after the rising edge has passed. A design that assigns the wrong bus to the wrong edge, or that ignores the direction swap in single-bus mode, therefore puts stale or wrong words into specific channels. Direction and mode are toggled in the middle of a sequence, so a design that follows the live inputs fills the wrong channels. The bench keeps driving fresh data after the sixth pair, which exposes a loader that keeps writing past the end of the bank. Back-to-back strobes at the last pair, and a strobe after only three pairs, catch two faults: a transfer that drops the final falling-edge word, and a restart that clears channels or continues from the wrong place.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int DEF_WORD_W = 12;
    localparam int DEF_NUM_CH = 12;

    typedef struct packed {
        logic dual;
        logic rev;
    } cfg_t;

    // Pair index written at a given step of the fill.
    function automatic int pair_of(input int step, input int npair, input logic rev);
        return rev ? (npair - 1 - step) : step;
    endfunction

endpackage

// File: rtl/pcl_seq.sv
module pcl_seq
    import pcl_pkg::*;
#(
    parameter int NUM_PAIR = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  cfg_t                          cfg_i,
    output logic                          commit_o,
    output logic                          wr_en_o,
    output logic [$clog2(NUM_PAIR+1)-1:0] pair_o,
    output cfg_t                          cfg_o,
    output logic                          xfer_o
);
    localparam int STEP_W = $clog2(NUM_PAIR + 1);

    logic              go_q;
    logic              busy_q;
    logic              xfer_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_eff;
    cfg_t              cfg_q;

    always_comb begin
        commit_o = go_q;
        cfg_o    = go_q ? cfg_i : cfg_q;
        wr_en_o  = go_q | busy_q;
        step_eff = go_q ? '0 : step_q;
        pair_o   = STEP_W'(pair_of(int'(step_eff), NUM_PAIR, cfg_o.rev));
        xfer_o   = xfer_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            busy_q <= 1'b0;
            xfer_q <= 1'b0;
            step_q <= '0;
            cfg_q  <= '0;
        end else begin
            go_q   <= start_i;
            xfer_q <= go_q;
            if (go_q) begin
                cfg_q  <= cfg_i;
                step_q <= STEP_W'(1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                step_q <= step_q + STEP_W'(1);
                if (step_q == STEP_W'(NUM_PAIR - 1)) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pcl_negcap.sv
module pcl_negcap #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] bus_a_i,
    input  logic [WORD_W-1:0] bus_b_i,
    output logic [WORD_W-1:0] neg_a_o,
    output logic [WORD_W-1:0] neg_b_o
);
    always_ff @(negedge clk) begin
        if (rst) begin
            neg_a_o <= '0;
            neg_b_o <= '0;
        end else begin
            neg_a_o <= bus_a_i;
            neg_b_o <= bus_b_i;
        end
    end

endmodule

// File: rtl/pcl_bank.sv
module pcl_bank
    import pcl_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int NUM_CH = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit_i,
    input  logic                              wr_en_i,
    input  logic [$clog2(NUM_CH/2+1)-1:0]     pair_i,
    input  cfg_t                              cfg_i,
    input  logic [WORD_W-1:0]                 bus_a_i,
    input  logic [WORD_W-1:0]                 bus_b_i,
    input  logic [WORD_W-1:0]                 neg_a_i,
    input  logic [WORD_W-1:0]                 neg_b_i,
    output logic [NUM_CH*WORD_W-1:0]          codes_o
);
    localparam int CW = $clog2(NUM_CH);

    typedef logic [WORD_W-1:0] word_t;

    word_t          ch_q  [NUM_CH];
    word_t          ch_m  [NUM_CH];
    word_t          ch_n  [NUM_CH];
    word_t          out_q [NUM_CH];
    logic           pend_q;
    logic           pend_a_q;
    logic [CW-1:0]  pend_ch_q;
    logic [CW-1:0]  idx_e;
    logic [CW-1:0]  idx_o;

    assign idx_e = CW'(2 * int'(pair_i));
    assign idx_o = CW'(2 * int'(pair_i) + 1);

    // Fold the word caught on the last falling edge into its channel.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ch_m[i] = ch_q[i];
        end
        if (pend_q) begin
            ch_m[pend_ch_q] = pend_a_q ? neg_a_i : neg_b_i;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ch_n[i] = ch_m[i];
        end
        if (wr_en_i) begin
            if (cfg_i.dual) begin
                ch_n[idx_e] = bus_a_i;
                ch_n[idx_o] = bus_b_i;
            end else if (cfg_i.rev) begin
                ch_n[idx_o] = bus_b_i;
            end else begin
                ch_n[idx_e] = bus_a_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) begin
                ch_q[i]  <= '0;
                out_q[i] <= '0;
            end
            pend_q    <= 1'b0;
            pend_a_q  <= 1'b0;
            pend_ch_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                ch_q[i] <= ch_n[i];
                if (commit_i) begin
                    out_q[i] <= ch_m[i];
                end
            end
            pend_q    <= wr_en_i & ~cfg_i.dual;
            pend_a_q  <= cfg_i.rev;
            pend_ch_q <= cfg_i.rev ? idx_e : idx_o;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        assign codes_o[g*WORD_W +: WORD_W] = out_q[g];
    end

endmodule

// File: rtl/pixel_chan_loader.sv
module pixel_chan_loader
    import pcl_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     dir_i,
    input  logic                     dual_i,
    input  logic [WORD_W-1:0]        bus_a_i,
    input  logic [WORD_W-1:0]        bus_b_i,
    output logic [NUM_CH*WORD_W-1:0] codes_o,
    output logic                     xfer_o
);
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam int PW       = $clog2(NUM_PAIR + 1);

    cfg_t              cfg_in;
    cfg_t              cfg_act;
    logic              commit;
    logic              wr_en;
    logic [PW-1:0]     pair;
    logic [WORD_W-1:0] neg_a;
    logic [WORD_W-1:0] neg_b;

    assign cfg_in = '{dual: dual_i, rev: dir_i};

    pcl_seq #(.NUM_PAIR(NUM_PAIR)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cfg_i    (cfg_in),
        .commit_o (commit),
        .wr_en_o  (wr_en),
        .pair_o   (pair),
        .cfg_o    (cfg_act),
        .xfer_o   (xfer_o)
    );

    pcl_negcap #(.WORD_W(WORD_W)) u_neg (
        .clk     (clk),
        .rst     (rst),
        .bus_a_i (bus_a_i),
        .bus_b_i (bus_b_i),
        .neg_a_o (neg_a),
        .neg_b_o (neg_b)
    );

    pcl_bank #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .wr_en_i  (wr_en),
        .pair_i   (pair),
        .cfg_i    (cfg_act),
        .bus_a_i  (bus_a_i),
        .bus_b_i  (bus_b_i),
        .neg_a_i  (neg_a),
        .neg_b_i  (neg_b),
        .codes_o  (codes_o)
    );

endmodule

// File: rtl/pcl_chk.sv
module pcl_chk #(
    parameter int WORD_W = 12,
    parameter int NUM_CH = 12
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start_i,
    input logic                     xfer_o,
    input logic [NUM_CH*WORD_W-1:0] codes_o
);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (codes_o == '0 && !xfer_o));

    // R2
    p_xfer_follows_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ##1 xfer_o);

    // R2
    p_xfer_cause_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_o |-> $past(start_i, 2));

    // R2
    p_codes_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!xfer_o && !$past(rst)) |-> $stable(codes_o));

endmodule

bind pixel_chan_loader pcl_chk #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .xfer_o  (xfer_o),
    .codes_o (codes_o)
);

// File: tb/pixel_chan_loader_tb.sv
`timescale 1ns/1ps
module pixel_chan_loader_tb;
    localparam int W  = 12;
    localparam int N  = 12;
    localparam int NP = N / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         dir_i = 1'b0;
    logic         dual_i = 1'b0;
    logic [W-1:0] bus_a_i = '0;
    logic [W-1:0] bus_b_i = '0;
    logic [N*W-1:0] codes_o;
    logic         xfer_o;

    always #2 clk = ~clk;

    pixel_chan_loader #(.WORD_W(W), .NUM_CH(N)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .dir_i   (dir_i),
        .dual_i  (dual_i),
        .bus_a_i (bus_a_i),
        .bus_b_i (bus_b_i),
        .codes_o (codes_o),
        .xfer_o  (xfer_o)
    );

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    logic [N*W-1:0] exp_q [$];
    string          tag_q [$];

    // Reference model state, built from the requirements.
    logic [W-1:0] mdl [N];
    logic         go_pend = 1'b0;
    logic         m_busy = 1'b0;
    int           m_step = 0;
    logic         m_dual = 1'b0;
    logic         m_rev = 1'b0;
    logic         pend_v = 1'b0;
    logic         pend_bus_a = 1'b0;
    logic [W-1:0] pend_w = '0;
    int           wcnt = 1;
    int           gcnt = 0;
    string        chk_tag = "R1";

    function automatic logic [N*W-1:0] pack_mdl();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = mdl[i];
        return v;
    endfunction

    // One clock cycle: drive inputs for the next rising edge and advance the model.
    task automatic tick(input logic st);
        logic [W-1:0] a, b, wa, wb;
        int p;
        gcnt++;
        a = W'(gcnt * 53 + 1365);
        b = W'(gcnt * 97 + 2730);
        if (pend_v) begin
            if (pend_bus_a) a = pend_w; else b = pend_w;
            pend_v = 1'b0;
        end
        if (go_pend) begin
            exp_q.push_back(pack_mdl());
            tag_q.push_back(chk_tag);
            m_dual = dual_i;
            m_rev  = dir_i;
            m_step = 0;
            m_busy = 1'b1;
        end
        if (m_busy) begin
            wa = W'(wcnt * 149 + 7);
            wb = W'(wcnt * 211 + 3) ^ 12'h800;
            wcnt++;
            p = m_rev ? (NP - 1 - m_step) : m_step;
            mdl[2*p]   = wa;
            mdl[2*p+1] = wb;
            if (m_dual) begin
                a = wa;
                b = wb;
            end else if (m_rev) begin
                b = wb;
                pend_w = wa; pend_bus_a = 1'b1; pend_v = 1'b1;
            end else begin
                a = wa;
                pend_w = wb; pend_bus_a = 1'b0; pend_v = 1'b1;
            end
            m_step++;
            if (m_step == NP) m_busy = 1'b0;
        end
        go_pend = st;
        start_i = st;
        bus_a_i = a;
        bus_b_i = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    // Monitor: compare each transfer against the scoreboard.
    initial begin
        logic [N*W-1:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (!rst && xfer_o) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: unexpected transfer pulse, actual xfer_o=1 expected 0");
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    for (int c = 0; c < N; c++) begin
                        checks++;
                        if (codes_o[c*W +: W] !== e[c*W +: W]) begin
                            errors++;
                            $display("FAIL %s: channel %0d actual %h expected %h",
                                     t, c, codes_o[c*W +: W], e[c*W +: W]);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (codes_o !== '0 || xfer_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: after reset actual codes=%h xfer=%b expected 0 0", codes_o, xfer_o);
        end
        @(posedge clk);
        #1;

        // Dual-bus, upward; first transfer shows reset contents (R1).
        dual_i = 1'b1; dir_i = 1'b0;
        chk_tag = "R1";
        tick(1'b1);
        idle(NP);
        idle(3);                       // data after full bank is ignored (R8)

        // Dual-bus, downward, with live mode/direction toggled mid-fill (R7).
        dual_i = 1'b1; dir_i = 1'b1;
        chk_tag = "R3_R8";
        tick(1'b1);
        tick(1'b0);
        dual_i = 1'b0; dir_i = 1'b0;
        idle(NP - 1);
        idle(2);

        // Single-bus, upward.
        dual_i = 1'b0; dir_i = 1'b0;
        chk_tag = "R4_R7";
        tick(1'b1);
        idle(NP);
        idle(2);

        // Single-bus, downward, then back-to-back restart at the last pair (R10).
        dual_i = 1'b0; dir_i = 1'b1;
        chk_tag = "R5";
        tick(1'b1);
        idle(NP - 1);
        chk_tag = "R6_R10";
        tick(1'b1);
        idle(NP);
        idle(3);

        // Dual-bus, upward, strobe after three pairs (R9).
        dual_i = 1'b1; dir_i = 1'b0;
        chk_tag = "R6_R8";
        tick(1'b1);
        tick(1'b0);
        tick(1'b0);
        chk_tag = "R9";
        tick(1'b1);
        idle(NP - 1);
        idle(2);

        // Final commit of the restarted fill.
        chk_tag = "R9_R3";
        tick(1'b1);
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: missing transfers, actual pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule